// File: doc/BRIEF.md
# Prioritized Interrupt Controller Bank

This block gathers 32 interrupt inputs into one bank. Each input has a pending bit, a mask bit and a small configuration register. The configuration register chooses between a normal interrupt line and a fast interrupt line, between edge and level sensing, and sets a 5-bit priority. Pending sources that are not masked compete separately for each of the two outputs. The winner's index is latched and its output is raised. Both stay frozen until software writes an acknowledge. One clock after that write, the bank picks a new winner.

A bank built with `FIRST_LEVEL = 0` has no fast path and acts as a second-level bank. Its normal output is wired to input 0 of a first-level bank, and that input is set to level sensing. A source on the second-level bank is serviced by reading both index registers and then acknowledging both banks.

The register port is a plain address/write-enable/data port. Read data is combinational.

Top module: `intcBank`

## Requirements
- R1: After reset, the mask register reads 0xFFFFFFFF and every configuration register reads 0. Both outputs are low and both index registers read 0. Whenever an output is low, its index register reads 0.
- R2: The mask register is at byte offset 0x04 and a 1 bit masks that source. A masked source never raises an output, but its bit still shows in the pending register at offset 0x00.
- R3: The configuration register of source i is at offset 0x80 + 4*i. Bit 0 selects the fast route, bit 1 selects level sensing, and bits 6:2 hold the priority. Reads return only these 7 bits, and the other bits read 0.
- R4: Among the eligible sources of one output, the lowest priority value wins. On equal priority, the lower source index wins.
- R5: An edge-sensed source (bit 1 = 0) latches a sticky pending bit on a rising input. The bit clears when that source's winning result is acknowledged. It also clears when software writes 0 to its bit at offset 0x00, and a 1 written there leaves the bit unchanged.
- R6: A level-sensed source (bit 1 = 1) has a pending bit that follows its input with one clock of delay. Acknowledging it while the input is still high makes it win again.
- R7: Once an output is raised, the output and its index register hold their values until that output is acknowledged, even if a better source appears.
- R8: Writing bit 0 of the control register at offset 0x10 acknowledges the normal output, and bit 1 acknowledges the fast output. The acknowledged output is low in the cycle after the write. A new result appears one clock after that. The other output is not affected.
- R9: The normal index register is at offset 0x08 and the fast index register is at offset 0x0C. Sources with bit 0 set compete only for the fast output. In a bank with `FIRST_LEVEL = 0`, bit 0 is dropped on write and reads as 0.
- R10: A second-level bank's normal output, fed into level-sensed input 0 of a first-level bank, raises the first-level normal output with index 0. Acknowledging both banks then drops both outputs.
- R11: Reads of unused offsets and of the control register return 0. Writes to the index registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 32 | Interrupt source inputs |
| busAddr | input | ADDR_W | Register byte address |
| busWrEn | input | 1 | Register write strobe |
| busWdata | input | DATA_W | Register write data |
| busRdata | output | DATA_W | Register read data (combinational) |
| irqOut | output | 1 | Registered normal interrupt output |
| fiqOut | output | 1 | Registered fast interrupt output |

## Verification
Arbitration is tried with three patterns. The first is three sources raised in the same cycle, two of them with equal priority, which separates the rule "lower value wins" from the rule "lower index wins". The second raises a better source while a result is already held, which shows that the hold works and that there is no preemption. The third acknowledges a level source whose input is still high, and then again after the input has dropped, which separates level sensing from sticky edge latching.

Further tests cover:
- a masked edge;
- a software clear;
- one source on the fast route, acknowledged separately from the normal output;
- a real two-bank cascade.

These show that the mask, the route split and the pair of acknowledges each act on their own.

// File: rtl/intcPkg.sv
package intcPkg;
  localparam int NSRC   = 32;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int PRIO_W = 5;

  localparam logic [7:0] OFS_PEND   = 8'h00;
  localparam logic [7:0] OFS_MASK   = 8'h04;
  localparam logic [7:0] OFS_IRQIDX = 8'h08;
  localparam logic [7:0] OFS_FIQIDX = 8'h0C;
  localparam logic [7:0] OFS_CTRL   = 8'h10;
  localparam logic [7:0] OFS_LVL    = 8'h80;

  typedef enum logic [2:0] {
    RD_NONE, RD_PEND, RD_MASK, RD_IRQIDX, RD_FIQIDX, RD_LVL
  } rdSel_e;

  typedef struct packed {
    logic             wrPend;
    logic             wrMask;
    logic             wrLvl;
    logic             ackIrq;
    logic             ackFiq;
    logic [IDX_W-1:0] lvlIdx;
    rdSel_e           rdSel;
  } strobe_t;
endpackage

// File: rtl/intcArbiter.sv
module intcArbiter #(
  parameter int NUM    = 32,
  parameter int PRIO_W = 5
) (
  input  logic [NUM-1:0]        cand,
  input  logic [NUM*PRIO_W-1:0] prioFlat,
  output logic                  found,
  output logic [$clog2(NUM)-1:0] winIdx
);
  localparam int IDX_W = $clog2(NUM);

  logic [PRIO_W-1:0] best;

  // Linear scan: strict less-than keeps the lower index on a tie.
  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    best   = '1;
    for (int i = 0; i < NUM; i++) begin
      if (cand[i] && (!found || (prioFlat[i*PRIO_W +: PRIO_W] < best))) begin
        found  = 1'b1;
        winIdx = IDX_W'(i);
        best   = prioFlat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/intcCtrl.sv
module intcCtrl import intcPkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [1:0]        ackBits,
  output strobe_t           strobe
);
  localparam int LVL_BASE = int'(OFS_LVL);
  localparam int LVL_END  = LVL_BASE + 4 * NSRC;

  logic [ADDR_W-1:0] wordAddr;
  logic [ADDR_W-1:0] lvlDiff;
  logic              inLvl;

  assign wordAddr = busAddr & ~ADDR_W'(3);
  assign lvlDiff  = wordAddr - ADDR_W'(LVL_BASE);
  assign inLvl    = (int'(wordAddr) >= LVL_BASE) && (int'(wordAddr) < LVL_END);

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RD_NONE;
    strobe.lvlIdx = lvlDiff[2 +: IDX_W];
    if (inLvl) begin
      strobe.rdSel = RD_LVL;
      strobe.wrLvl = busWrEn;
    end else begin
      case (wordAddr)
        ADDR_W'(OFS_PEND): begin
          strobe.rdSel  = RD_PEND;
          strobe.wrPend = busWrEn;
        end
        ADDR_W'(OFS_MASK): begin
          strobe.rdSel  = RD_MASK;
          strobe.wrMask = busWrEn;
        end
        ADDR_W'(OFS_IRQIDX): strobe.rdSel = RD_IRQIDX;
        ADDR_W'(OFS_FIQIDX): strobe.rdSel = RD_FIQIDX;
        ADDR_W'(OFS_CTRL): begin
          strobe.ackIrq = busWrEn && ackBits[0];
          strobe.ackFiq = busWrEn && ackBits[1];
        end
        default: strobe.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/intcDatapath.sv
module intcDatapath import intcPkg::*; #(
  parameter bit FIRST_LEVEL = 1'b1,
  parameter int DATA_W      = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSRC-1:0]  srcIn,
  input  strobe_t          strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic             irqOut,
  output logic             fiqOut,
  output logic [IDX_W-1:0] irqIdx,
  output logic [IDX_W-1:0] fiqIdx
);
  localparam int NOUT = 2;  // 0: normal, 1: fast

  logic [NSRC-1:0]   maskQ, pendQ, srcPrevQ, trigQ, fiqRouteQ;
  logic [PRIO_W-1:0] prioQ [NSRC];
  logic [NSRC*PRIO_W-1:0] prioFlat;
  logic [NSRC-1:0]   rise, edgeKeep, pendNext;
  logic [NSRC-1:0]   cand   [NOUT];
  logic [NOUT-1:0]   found, holdVec, ackVec;
  logic [IDX_W-1:0]  winIdx [NOUT];
  logic [IDX_W-1:0]  idxVec [NOUT];

  // Configuration registers; the fast-route bit only exists in a first-level bank.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigQ     <= '0;
      fiqRouteQ <= '0;
      for (int i = 0; i < NSRC; i++) prioQ[i] <= '0;
    end else if (strobe.wrLvl) begin
      trigQ[strobe.lvlIdx]     <= busWdata[1];
      fiqRouteQ[strobe.lvlIdx] <= busWdata[0] & FIRST_LEVEL;
      prioQ[strobe.lvlIdx]     <= busWdata[2 +: PRIO_W];
    end
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++) prioFlat[i*PRIO_W +: PRIO_W] = prioQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskQ <= '1;
    else if (strobe.wrMask) maskQ <= busWdata[NSRC-1:0];
  end

  // Pending: level sources track the input, edge sources are sticky.
  assign ackVec = {strobe.ackFiq, strobe.ackIrq};
  always_comb begin
    rise     = srcIn & ~srcPrevQ;
    edgeKeep = pendQ;
    if (strobe.wrPend) edgeKeep = edgeKeep & busWdata[NSRC-1:0];
    for (int o = 0; o < NOUT; o++) begin
      if (ackVec[o] && holdVec[o]) edgeKeep[idxVec[o]] = 1'b0;
    end
    for (int i = 0; i < NSRC; i++) begin
      pendNext[i] = trigQ[i] ? srcIn[i] : (edgeKeep[i] | rise[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ    <= '0;
      srcPrevQ <= '0;
    end else begin
      pendQ    <= pendNext;
      srcPrevQ <= srcIn;
    end
  end

  assign cand[0] = pendQ & ~maskQ & ~fiqRouteQ;
  assign cand[1] = pendQ & ~maskQ & fiqRouteQ;

  // One arbiter and one hold stage per output.
  for (genvar o = 0; o < NOUT; o++) begin : g_out
    logic             holdQ;
    logic [IDX_W-1:0] idxQ;

    intcArbiter #(.NUM(NSRC), .PRIO_W(PRIO_W)) u_arb (
      .cand    (cand[o]),
      .prioFlat(prioFlat),
      .found   (found[o]),
      .winIdx  (winIdx[o])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdQ <= 1'b0;
        idxQ  <= '0;
      end else if (holdQ) begin
        if (ackVec[o]) begin
          holdQ <= 1'b0;
          idxQ  <= '0;
        end
      end else if (found[o]) begin
        holdQ <= 1'b1;
        idxQ  <= winIdx[o];
      end
    end

    assign holdVec[o] = holdQ;
    assign idxVec[o]  = idxQ;
  end

  assign irqOut = holdVec[0];
  assign fiqOut = holdVec[1];
  assign irqIdx = idxVec[0];
  assign fiqIdx = idxVec[1];

  always_comb begin
    case (strobe.rdSel)
      RD_PEND:   busRdata = DATA_W'(pendQ);
      RD_MASK:   busRdata = DATA_W'(maskQ);
      RD_IRQIDX: busRdata = DATA_W'(idxVec[0]);
      RD_FIQIDX: busRdata = DATA_W'(idxVec[1]);
      RD_LVL:    busRdata = DATA_W'({prioQ[strobe.lvlIdx], trigQ[strobe.lvlIdx],
                                     fiqRouteQ[strobe.lvlIdx]});
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/intcBank.sv
module intcBank import intcPkg::*; #(
  parameter bit FIRST_LEVEL = 1'b1,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              fiqOut
);
  strobe_t          strobe;
  logic [IDX_W-1:0] irqIdx, fiqIdx;

  intcCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .ackBits(busWdata[1:0]),
    .strobe (strobe)
  );

  intcDatapath #(.FIRST_LEVEL(FIRST_LEVEL), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .strobe  (strobe),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .irqOut  (irqOut),
    .fiqOut  (fiqOut),
    .irqIdx  (irqIdx),
    .fiqIdx  (fiqIdx)
  );
endmodule

// File: rtl/intcBankChk.sv
module intcBankChk import intcPkg::*; #(
  parameter bit FIRST_LEVEL = 1'b1,
  parameter int ADDR_W      = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [1:0]        ackBits,
  input logic              irqOut,
  input logic              fiqOut,
  input logic [IDX_W-1:0]  irqIdx,
  input logic [IDX_W-1:0]  fiqIdx
);
  logic ctrlWr, ackI, ackF;
  assign ctrlWr = busWrEn && ((busAddr & ~ADDR_W'(3)) == ADDR_W'(OFS_CTRL));
  assign ackI   = ctrlWr && ackBits[0];
  assign ackF   = ctrlWr && ackBits[1];

  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !ackI) |=> (irqOut && $stable(irqIdx)));
  a_r7_fiq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fiqOut && !ackF) |=> (fiqOut && $stable(fiqIdx)));
  a_r8_irq_ack_drop: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && ackI) |=> !irqOut);
  a_r8_fiq_ack_drop: assert property (@(posedge clk) disable iff (!rstN)
    (fiqOut && ackF) |=> !fiqOut);
  a_r1_irq_idle_idx: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (irqIdx == '0));
  a_r1_fiq_idle_idx: assert property (@(posedge clk) disable iff (!rstN)
    !fiqOut |-> (fiqIdx == '0));
  a_r9_no_fast_l2: assert property (@(posedge clk) disable iff (!rstN)
    !FIRST_LEVEL |-> !fiqOut);
endmodule

bind intcBank intcBankChk #(.FIRST_LEVEL(FIRST_LEVEL), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busAddr(busAddr),
  .busWrEn(busWrEn),
  .ackBits(busWdata[1:0]),
  .irqOut (irqOut),
  .fiqOut (fiqOut),
  .irqIdx (irqIdx),
  .fiqIdx (fiqIdx)
);

// File: tb/intcBank_tb.sv
`timescale 1ns/1ps
module intcBank_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] srcTb = '0, srcL2 = '0;
  logic [7:0]  aA = '0, aB = '0;
  logic        wA = 1'b0, wB = 1'b0;
  logic [31:0] dA = '0, dB = '0;
  logic [31:0] rdA, rdB;
  logic        irqA, fiqA, irqB, fiqB;

  intcBank #(.FIRST_LEVEL(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .srcIn({srcTb[31:1], irqB}),
    .busAddr(aA), .busWrEn(wA), .busWdata(dA), .busRdata(rdA),
    .irqOut(irqA), .fiqOut(fiqA));

  intcBank #(.FIRST_LEVEL(1'b0)) u_l2 (
    .clk(clk), .rstN(rstN), .srcIn(srcL2),
    .busAddr(aB), .busWrEn(wB), .busWdata(dB), .busRdata(rdB),
    .irqOut(irqB), .fiqOut(fiqB));

  // Scoreboard
  string       tagQ[$];
  logic [31:0] expQ[$], actQ[$];
  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  task automatic expectVal(string tag, logic [31:0] act, logic [31:0] exp);
    tagQ.push_back(tag); expQ.push_back(exp); actQ.push_back(act);
  endtask

  always @(posedge clk) begin
    while (actQ.size() > 0) begin
      string t; logic [31:0] e, a;
      t = tagQ.pop_front(); e = expQ.pop_front(); a = actQ.pop_front();
      nChecks++;
      if (a !== e) begin
        nFail++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit l2, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    if (l2) begin aB = a; dB = d; wB = 1'b1; end
    else    begin aA = a; dA = d; wA = 1'b1; end
    @(negedge clk);
    wA = 1'b0; wB = 1'b0;
  endtask

  task automatic chkReg(bit l2, logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    if (l2) aB = a; else aA = a;
    #1;
    expectVal(tag, l2 ? rdB : rdA, exp);
  endtask

  function automatic logic [7:0] lvlA(int i);
    return 8'(8'h80 + 4 * i);
  endfunction

  logic [31:0] maskA = 32'hFFFF_FFFF;

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    expectVal("R1 irqOut", {31'b0, irqA}, 0);
    expectVal("R1 fiqOut", {31'b0, fiqA}, 0);
    chkReg(0, 8'h04, 32'hFFFF_FFFF, "R1 mask");
    chkReg(0, 8'h08, 0, "R1 irq idx");
    chkReg(0, lvlA(5), 0, "R1 level reg");
    chkReg(1, 8'h04, 32'hFFFF_FFFF, "R1 l2 mask");

    // R3 level register layout
    wr(0, lvlA(3), 32'hFFFF_FF9C);
    chkReg(0, lvlA(3), 32'h0000_001C, "R3 level readback");

    // R2 masked source stays silent but pending
    @(negedge clk); srcTb[3] = 1'b1;
    idle(3);
    expectVal("R2 masked no irq", {31'b0, irqA}, 0);
    chkReg(0, 8'h00, 32'h8, "R2 pending visible");
    maskA[3] = 1'b0; wr(0, 8'h04, maskA);
    chkReg(0, 8'h08, 3, "R2 unmasked wins");

    // R7 hold while a better source arrives
    wr(0, lvlA(5), 32'h4);
    maskA[5] = 1'b0; wr(0, 8'h04, maskA);
    @(negedge clk); srcTb[5] = 1'b1;
    idle(3);
    chkReg(0, 8'h08, 3, "R7 index held");
    expectVal("R7 irq held", {31'b0, irqA}, 1);

    // R8 acknowledge timing
    wr(0, 8'h10, 32'h1);
    expectVal("R8 irq drops", {31'b0, irqA}, 0);
    chkReg(0, 8'h08, 5, "R8 new winner");
    expectVal("R8 irq re-raised", {31'b0, irqA}, 1);
    chkReg(0, 8'h00, 32'h20, "R5 ack clears sticky");
    @(negedge clk); srcTb[3] = 1'b0; srcTb[5] = 1'b0;
    wr(0, 8'h10, 32'h1);
    idle(2);

    // R5 software clear (masked source 6)
    @(negedge clk); srcTb[6] = 1'b1;
    idle(2);
    chkReg(0, 8'h00, 32'h40, "R5 edge sets sticky");
    wr(0, 8'h00, 32'hFFFF_FFBF);
    chkReg(0, 8'h00, 0, "R5 sw clear");
    @(negedge clk); srcTb[6] = 1'b0;

    // R4 priority and tie-break
    wr(0, lvlA(10), 32'h10);
    wr(0, lvlA(12), 32'h08);
    wr(0, lvlA(9),  32'h08);
    maskA[9] = 1'b0; maskA[10] = 1'b0; maskA[12] = 1'b0; wr(0, 8'h04, maskA);
    @(negedge clk); srcTb[9] = 1'b1; srcTb[10] = 1'b1; srcTb[12] = 1'b1;
    idle(3);
    chkReg(0, 8'h08, 9, "R4 tie lower index");
    wr(0, 8'h10, 32'h1);
    chkReg(0, 8'h08, 12, "R4 second");
    wr(0, 8'h10, 32'h1);
    chkReg(0, 8'h08, 10, "R4 third");
    wr(0, 8'h10, 32'h1);
    idle(2);
    expectVal("R4 queue empty", {31'b0, irqA}, 0);
    @(negedge clk); srcTb[9] = 1'b0; srcTb[10] = 1'b0; srcTb[12] = 1'b0;

    // R6 level-sensed source
    wr(0, lvlA(20), 32'h0E);
    maskA[20] = 1'b0; wr(0, 8'h04, maskA);
    @(negedge clk); srcTb[20] = 1'b1;
    idle(3);
    chkReg(0, 8'h08, 20, "R6 level wins");
    wr(0, 8'h10, 32'h1);
    chkReg(0, 8'h08, 20, "R6 re-wins while high");
    @(negedge clk); srcTb[20] = 1'b0;
    idle(2);
    wr(0, 8'h10, 32'h1);
    idle(2);
    expectVal("R6 quiet after drop", {31'b0, irqA}, 0);
    chkReg(0, 8'h00, 0, "R6 pending follows input");

    // R9 fast route
    wr(0, lvlA(25), 32'h1);
    maskA[25] = 1'b0; wr(0, 8'h04, maskA);
    @(negedge clk); srcTb[25] = 1'b1;
    idle(3);
    expectVal("R9 fast out", {31'b0, fiqA}, 1);
    expectVal("R9 normal quiet", {31'b0, irqA}, 0);
    chkReg(0, 8'h0C, 25, "R9 fast index");
    wr(0, 8'h10, 32'h1);
    idle(1);
    expectVal("R8 normal ack keeps fast", {31'b0, fiqA}, 1);
    wr(0, 8'h10, 32'h2);
    expectVal("R8 fast ack drops", {31'b0, fiqA}, 0);
    idle(2);
    expectVal("R8 fast stays low", {31'b0, fiqA}, 0);
    @(negedge clk); srcTb[25] = 1'b0;
    wr(1, lvlA(4), 32'h1);
    chkReg(1, lvlA(4), 0, "R9 l2 fast bit dropped");

    // R10 cascade
    wr(0, lvlA(0), 32'h2);
    maskA[0] = 1'b0; wr(0, 8'h04, maskA);
    wr(1, 8'h04, 32'hFFFF_FF7F);
    @(negedge clk); srcL2[7] = 1'b1;
    idle(6);
    expectVal("R10 l2 irq", {31'b0, irqB}, 1);
    expectVal("R10 top irq", {31'b0, irqA}, 1);
    chkReg(1, 8'h08, 7, "R10 l2 index");
    chkReg(0, 8'h08, 0, "R10 top index 0");
    expectVal("R9 l2 no fast", {31'b0, fiqB}, 0);
    wr(1, 8'h10, 32'h1);
    wr(0, 8'h10, 32'h1);
    idle(3);
    expectVal("R10 l2 released", {31'b0, irqB}, 0);
    expectVal("R10 top released", {31'b0, irqA}, 0);

    // R11 unused and read-only offsets
    chkReg(0, 8'h20, 0, "R11 unused 0x20");
    chkReg(0, 8'h14, 0, "R11 unused 0x14");
    chkReg(0, 8'h10, 0, "R11 control reads 0");
    wr(0, 8'h08, 32'h1F);
    chkReg(0, 8'h08, 0, "R11 index write ignored");

    idle(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule